// File: doc/BRIEF.md
# Core versus DMA External Bus Slot Arbiter

This block decides who owns a shared external bus in each bus slot. Four sources compete: three core access types (program fetch, X data, Y data) and the currently active DMA channel. At every slot boundary, marked by a one-cycle strobe, the arbiter compares a core priority with the DMA channel priority and registers a one-hot grant. That grant holds for the whole slot.

A 2-bit mode input controls how the core priority is set. In the dynamic mode, a 2-bit core priority value taken from the status register is compared numerically with the DMA channel's 2-bit priority. The other three modes fix the relationship: core below DMA, core equal to DMA, or core above DMA. When the winning side has no request, the other side gets the slot. When the two priorities are equal, the sources share the bus in a rotating order P, X, Y, DMA. The rotation skips sources that are not requesting.

Top module: `bus_slot_arbiter`

## Requirements
- R1: `grant` is one-hot or zero, with bit 0 = program fetch, bit 1 = X data, bit 2 = Y data, bit 3 = DMA. A slot with at least one request grants exactly one source. A slot with no request grants none.
- R2: `grant` clears on reset and changes only on a clock edge where `slot_strobe` is high. On all other edges it holds its value, whatever the requests do.
- R3: A source is granted only if it was requesting at the strobe edge that produced the grant. A lone requester always wins, whatever the priorities are.
- R4: With `arb_mode` = 00, the registered core priority (0 lowest, 3 highest) is compared with `dma_prio`. Higher core gives core first. Higher DMA gives DMA first. Equal values use the rotation.
- R5: With `arb_mode` = 01, a requesting DMA always wins the slot, and `core_prio` has no effect.
- R6: With `arb_mode` = 11, any core request beats DMA, and DMA is granted only in slots with no core request. `core_prio` has no effect.
- R7: With `arb_mode` = 10, or with equal priorities in mode 00, the grant goes to the first requesting source found from a rotation pointer in the order P, X, Y, DMA (wrapping to P). After every grant in any mode, the pointer moves to the source just after the granted one. The pointer resets to P.
- R8: When core and DMA priorities differ and the core side is served, program fetch beats X data, and X data beats Y data.
- R9: The core priority register resets to 3. After reset it loads `core_prio` on every clock edge. A slot decision uses the value loaded on the edge before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_strobe | input | 1 | High for one cycle at each slot boundary |
| req_p | input | 1 | Core program-fetch request |
| req_x | input | 1 | Core X-data request |
| req_y | input | 1 | Core Y-data request |
| req_dma | input | 1 | Active DMA channel request |
| arb_mode | input | 2 | 00 dynamic, 01 core below, 10 equal, 11 core above |
| core_prio | input | PRIO_W | Status-register core priority (used in mode 00) |
| dma_prio | input | PRIO_W | Priority of the active DMA channel |
| grant | output | 4 | One-hot slot grant {DMA, Y, X, P} |

## Verification
The bench releases reset with a low core priority on the input and strobes in that same cycle. A design that skipped the reset value of 3, or that compared the raw input, would hand that first slot to DMA instead of the program fetch. The bench walks the rotation through a full P, X, Y, DMA cycle and then with only P and DMA requesting. A pointer that fails to skip idle sources, or that moves only on rotation slots, shows up there as a wrong source. It also strobes with no requests and changes requests between strobes, which catches spurious grants and grants that follow the request lines between slots. Fixed modes are run with a core priority that would contradict them, so a design that reads `core_prio` outside mode 00 picks the wrong side.

// File: rtl/arb_pkg.sv
// Package: shared source indices, mode codes and priority relation type
// for the external bus slot arbiter.
package arb_pkg;

    localparam int SRC_N   = 4;
    localparam int CORE_N  = 3;
    localparam int SRC_P   = 0;
    localparam int SRC_X   = 1;
    localparam int SRC_Y   = 2;
    localparam int SRC_DMA = 3;

    typedef enum logic [1:0] {
        MODE_DYNAMIC   = 2'b00,
        MODE_CORE_LOW  = 2'b01,
        MODE_TIE       = 2'b10,
        MODE_CORE_HIGH = 2'b11
    } arb_mode_e;

    typedef enum logic [1:0] {
        REL_CORE_LOW  = 2'b00,
        REL_EQUAL     = 2'b01,
        REL_CORE_HIGH = 2'b10
    } arb_rel_e;

endpackage

// File: rtl/arb_rel_decode.sv
// Module: arb_rel_decode
// Holds the core priority register and resolves the core/DMA priority
// relation for the current slot from the mode code.
// Assumes: mode values follow arb_pkg::arb_mode_e; the register resets to
// the all-ones (highest) priority and reloads every clock.
module arb_rel_decode
    import arb_pkg::*;
#(
    parameter int PRIO_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [PRIO_W-1:0] cp_in,
    input  logic [PRIO_W-1:0] dma_prio,
    output arb_rel_e          rel
);

    localparam logic [PRIO_W-1:0] CP_RESET = {PRIO_W{1'b1}};

    logic [PRIO_W-1:0] cp_q;

    // Core priority register: resets to highest, then tracks the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cp_q <= CP_RESET;
        end else begin
            cp_q <= cp_in;
        end
    end

    // Relation decode: dynamic compare or one of three fixed outcomes.
    always_comb begin
        unique case (mode)
            MODE_CORE_LOW:  rel = REL_CORE_LOW;
            MODE_TIE:       rel = REL_EQUAL;
            MODE_CORE_HIGH: rel = REL_CORE_HIGH;
            default: begin
                if (cp_q > dma_prio) begin
                    rel = REL_CORE_HIGH;
                end else if (cp_q < dma_prio) begin
                    rel = REL_CORE_LOW;
                end else begin
                    rel = REL_EQUAL;
                end
            end
        endcase
    end

endmodule

// File: rtl/arb_fixed_pick.sv
// Module: arb_fixed_pick
// Lowest-index-first one-hot pick over N request lines.
// Assumes: index 0 has the highest priority.
module arb_fixed_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // Priority chain: each stage wins only if no lower index requested.
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign gnt[i]    = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    assign any = seen[N];

endmodule

// File: rtl/arb_rr_pick.sv
// Module: arb_rr_pick
// Rotating one-hot pick: the search starts at index ptr and wraps.
// Assumes: ptr < N.
module arb_rr_pick #(
    parameter int N     = 4,
    parameter int PTR_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    input  logic [PTR_W-1:0] ptr,
    output logic [N-1:0]     gnt
);

    // Rotating search from the pointer, first requester wins.
    always_comb begin
        logic found;
        int   j;
        gnt   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            j = (int'(ptr) + k) % N;
            if (!found && req[j]) begin
                gnt[j] = 1'b1;
                found  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bus_slot_arbiter.sv
// Module: bus_slot_arbiter
// Grants each external bus slot to one of P, X, Y core accesses or the
// active DMA channel. Grant is registered at each slot strobe and held.
// Assumes: slot_strobe is a single-cycle pulse; sources keep requesting
// until served (no internal queueing).
module bus_slot_arbiter
    import arb_pkg::*;
#(
    parameter int PRIO_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_strobe,
    input  logic              req_p,
    input  logic              req_x,
    input  logic              req_y,
    input  logic              req_dma,
    input  logic [1:0]        arb_mode,
    input  logic [PRIO_W-1:0] core_prio,
    input  logic [PRIO_W-1:0] dma_prio,
    output logic [3:0]        grant
);

    localparam int PTR_W = $clog2(SRC_N);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(SRC_N - 1);

    arb_rel_e           rel;
    logic [SRC_N-1:0]   req_all;
    logic [CORE_N-1:0]  core_req;
    logic [CORE_N-1:0]  core_gnt;
    logic               core_any;
    logic [SRC_N-1:0]   rr_gnt;
    logic [SRC_N-1:0]   pick;
    logic [PTR_W-1:0]   ptr_q;
    logic [PTR_W-1:0]   pick_idx;
    logic [PTR_W-1:0]   ptr_next;
    logic [SRC_N-1:0]   grant_q;

    assign core_req = {req_y, req_x, req_p};
    assign req_all  = {req_dma, core_req};

    arb_rel_decode #(.PRIO_W(PRIO_W)) u_rel (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (arb_mode),
        .cp_in    (core_prio),
        .dma_prio (dma_prio),
        .rel      (rel)
    );

    arb_fixed_pick #(.N(CORE_N)) u_core_pick (
        .req (core_req),
        .gnt (core_gnt),
        .any (core_any)
    );

    arb_rr_pick #(.N(SRC_N), .PTR_W(PTR_W)) u_rr (
        .req (req_all),
        .ptr (ptr_q),
        .gnt (rr_gnt)
    );

    // Slot winner: rotation on a tie, otherwise the favoured side first.
    always_comb begin
        pick = '0;
        unique case (rel)
            REL_EQUAL: pick = rr_gnt;
            REL_CORE_HIGH: begin
                if (core_any) begin
                    pick[CORE_N-1:0] = core_gnt;
                end else begin
                    pick[SRC_DMA] = req_dma;
                end
            end
            default: begin
                if (req_dma) begin
                    pick[SRC_DMA] = 1'b1;
                end else begin
                    pick[CORE_N-1:0] = core_gnt;
                end
            end
        endcase
    end

    // Index of the winner, used to move the rotation pointer past it.
    always_comb begin
        pick_idx = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (pick[i]) begin
                pick_idx = PTR_W'(i);
            end
        end
        ptr_next = (pick_idx == PTR_LAST) ? '0 : pick_idx + 1'b1;
    end

    // Slot registers: grant and pointer update only at a slot boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            ptr_q   <= '0;
        end else if (slot_strobe) begin
            grant_q <= pick;
            if (|pick) begin
                ptr_q <= ptr_next;
            end
        end
    end

    assign grant = grant_q;

endmodule

// File: rtl/bus_slot_arbiter_chk.sv
// Module: bus_slot_arbiter_chk
// Property checker for bus_slot_arbiter, attached by bind below.
// Assumes: sampled on the same clock and reset as the arbiter.
module bus_slot_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       slot_strobe,
    input logic       req_p,
    input logic       req_x,
    input logic       req_y,
    input logic       req_dma,
    input logic [1:0] arb_mode,
    input logic [3:0] grant
);

    logic [3:0] rv;
    assign rv = {req_dma, req_y, req_x, req_p};

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r1_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_strobe && rv == 4'b0000) |=> grant == 4'b0000);

    a_r1_busy_one: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_strobe && rv != 4'b0000) |=> $countones(grant) == 1);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_strobe |=> $stable(grant));

    a_r3_requester: assert property (@(posedge clk) disable iff (!rst_n)
        slot_strobe |=> (grant & ~$past(rv)) == 4'b0000);

    a_r5_dma_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_strobe && arb_mode == 2'b01 && req_dma) |=> grant == 4'b1000);

    a_r6_core_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_strobe && arb_mode == 2'b11 && (req_p || req_x || req_y))
        |=> !grant[3]);

    a_r8_p_first: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_strobe && arb_mode == 2'b11 && req_p) |=> grant == 4'b0001);

endmodule

bind bus_slot_arbiter bus_slot_arbiter_chk u_chk (.*);

// File: tb/bus_slot_arbiter_bench.sv
module bus_slot_arbiter_bench;

    typedef struct {
        logic [3:0] exp;
        int         due;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_strobe = 1'b0;
    logic       req_p = 1'b0, req_x = 1'b0, req_y = 1'b0, req_dma = 1'b0;
    logic [1:0] arb_mode = 2'b00;
    logic [1:0] core_prio = 2'b00;
    logic [1:0] dma_prio = 2'b00;
    logic [3:0] grant;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb[$];
    logic [3:0] last_exp = 4'b0000;

    bus_slot_arbiter u_bus_slot_arbiter (
        .clk(clk), .rst_n(rst_n), .slot_strobe(slot_strobe),
        .req_p(req_p), .req_x(req_x), .req_y(req_y), .req_dma(req_dma),
        .arb_mode(arb_mode), .core_prio(core_prio), .dma_prio(dma_prio),
        .grant(grant)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop and compare items that fall due this cycle.
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (grant !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%b expected=%b", it.tag, grant, it.exp);
            end
        end
    end

    task automatic push(input logic [3:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.due = cyc + 1;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Driver: a settle cycle (hold check) then a strobed slot.
    task automatic do_slot(input logic [3:0] rq, input logic [1:0] md,
                           input logic [1:0] cp, input logic [1:0] dp,
                           input logic [3:0] e, input string tag);
        @(negedge clk);
        slot_strobe = 1'b0;
        {req_dma, req_y, req_x, req_p} = rq;
        arb_mode  = md;
        core_prio = cp;
        dma_prio  = dp;
        push(last_exp, {"R2 hold before ", tag});
        @(negedge clk);
        slot_strobe = 1'b1;
        push(e, tag);
        last_exp = e;
    endtask

    initial begin
        {req_dma, req_y, req_x, req_p} = 4'b1001;
        dma_prio = 2'd2;
        repeat (3) @(negedge clk);
        checks++;
        if (grant !== 4'b0000) begin
            errors++;
            $display("FAIL R2 reset actual=%b expected=%b", grant, 4'b0000);
        end
        // R9: first slot after reset uses the reset core priority 3.
        rst_n = 1'b1;
        slot_strobe = 1'b1;
        push(4'b0001, "R9 reset core prio");
        last_exp = 4'b0001;
        do_slot(4'b1001, 2'b00, 2'd0, 2'd2, 4'b1000, "R9 loaded core prio");
        do_slot(4'b0000, 2'b00, 2'd0, 2'd2, 4'b0000, "R1 no request");
        do_slot(4'b0010, 2'b11, 2'd0, 2'd2, 4'b0010, "R6 X alone");
        do_slot(4'b1111, 2'b11, 2'd0, 2'd2, 4'b0001, "R8 P first");
        do_slot(4'b1110, 2'b11, 2'd0, 2'd2, 4'b0010, "R8 X before Y");
        do_slot(4'b1000, 2'b11, 2'd0, 2'd2, 4'b1000, "R6 DMA when core idle");
        do_slot(4'b1111, 2'b01, 2'd3, 2'd0, 4'b1000, "R5 DMA wins");
        do_slot(4'b0110, 2'b01, 2'd3, 2'd0, 4'b0010, "R5 core X when DMA idle");
        do_slot(4'b1111, 2'b10, 2'd0, 2'd3, 4'b0100, "R7 rotate Y");
        do_slot(4'b1111, 2'b10, 2'd0, 2'd3, 4'b1000, "R7 rotate DMA");
        do_slot(4'b1111, 2'b10, 2'd0, 2'd3, 4'b0001, "R7 rotate P");
        do_slot(4'b1111, 2'b10, 2'd0, 2'd3, 4'b0010, "R7 rotate X");
        do_slot(4'b1001, 2'b10, 2'd0, 2'd3, 4'b1000, "R7 skip to DMA");
        do_slot(4'b1001, 2'b10, 2'd0, 2'd3, 4'b0001, "R7 wrap to P");
        do_slot(4'b1001, 2'b10, 2'd0, 2'd3, 4'b1000, "R7 skip X Y");
        do_slot(4'b0011, 2'b00, 2'd1, 2'd1, 4'b0001, "R4 equal rotate");
        do_slot(4'b1111, 2'b00, 2'd3, 2'd2, 4'b0001, "R4 core higher");
        do_slot(4'b1010, 2'b00, 2'd1, 2'd2, 4'b1000, "R4 DMA higher");
        do_slot(4'b1110, 2'b00, 2'd2, 2'd2, 4'b0010, "R4 equal from P");
        do_slot(4'b1000, 2'b00, 2'd3, 2'd0, 4'b1000, "R3 lone DMA");
        do_slot(4'b0100, 2'b01, 2'd0, 2'd3, 4'b0100, "R3 lone Y");
        @(negedge clk);
        slot_strobe = 1'b0;
        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule